// File: doc/BRIEF.md
# Chained-Word SPI Master with Held Chip Select

This block is an SPI master that shifts words of 4 to 16 bits in clock mode 0. Longer frames are built by chaining several words. Each transmit word comes with its own length and two flags. The end-of-frame flag marks the last word of a logical frame. The hold flag keeps chip select asserted after the word ends, so the slave sees one continuous frame across word boundaries. A sequencer can therefore read a 24-bit sensor as 16+8, 12+12 or 8+8+8 bits, and chip select stays low for the whole read.

The block holds a single transmit entry. The producer offers a word with a valid/ready handshake. If the next word is already offered when a held word finishes, it starts on the very next SCK low phase with no idle time. An optional frame delay adds idle time after an end-of-frame word. After each word, the block returns the received bits right-aligned, together with that word's end-of-frame flag.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, csN is high, sck is low, rxValid is low and txReady is high.
- R2: A word with length code L (3 to 15) shifts L+1 bits out on mosi, most significant bit first. The slave captures each bit on a rising edge of sck.
- R3: Length codes 0, 1 and 2 send a 4-bit word, the same as code 3.
- R4: Each sck high phase and each low phase lasts halfDiv+1 clock cycles. Within a word, consecutive rising edges are 2*(halfDiv+1) cycles apart. sck stays low whenever csN is high.
- R5: miso is sampled on the rising edges of sck. After the last bit of a word, rxValid pulses for exactly one cycle, while sck is low. With it, rxData carries the received bits right-aligned and zero-extended, and rxEof carries the word's end-of-frame flag.
- R6: csN falls when a word is accepted while idle. csN stays low after a word whose hold flag is 1, including while waiting for the next word. csN rises only at the end of a word whose hold flag is 0, in the same cycle that rxValid rises.
- R7: When a held word ends and the next word is already valid, the next word starts with no gap. The rising edges on either side of the boundary are 2*(halfDiv+1) cycles apart.
- R8: After a word with the end-of-frame flag and frameDelay=D>0, sck stays low for an extra D*(halfDiv+1)+1 cycles. The boundary interval then becomes (2+D)*(halfDiv+1)+1 cycles. With D=0 the end-of-frame flag adds no delay.
- R9: txReady is high only while idle, or in the final cycle of a held word that can chain. It is low in the cycle after every accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfDiv | input | 8 | SCK half-period minus one, in clock cycles |
| frameDelay | input | 8 | Idle half-periods after an end-of-frame word |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit word taken at this edge if txValid |
| txData | input | 16 | Transmit bits, right-aligned |
| txLen | input | 4 | Word length minus one |
| txEof | input | 1 | Word closes a logical frame |
| txHold | input | 1 | Keep chip select asserted after this word |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |
| rxValid | output | 1 | One-cycle pulse: received word available |
| rxData | output | 16 | Received bits, right-aligned |
| rxEof | output | 1 | End-of-frame flag of the received word |

## Verification
The bench acts as a slave that records every mosi bit and every sck rising edge, and that returns a known pattern on miso across whole chip-select sessions. One group of corner cases is the chained boundaries: 16+8, 12+12 and 8+8+8 with the next word already waiting. A design that inserts an idle cycle there shows a widened rising-edge interval, and one that drops chip select between words shows an extra csN rise. The frame-delay case and the end-of-frame-with-zero-delay case check that idle time appears only when it is requested. Another group covers short length codes, a hold on a word with nothing queued behind it, and the per-word right alignment of received bits. Errors in those cases would show up as wrong bit counts, an early chip-select release, or shifted receive data.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new transmit word
    logic sample;  // capture miso (sck about to rise)
    logic shift;   // advance to next bit (sck about to fall)
    logic finish;  // last bit of the word is complete
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/spi_chain_dp.sv
module spi_chain_dp
  import spi_chain_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 4,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [LEN_W-1:0]    txLen,
  input  logic                txEof,
  input  logic                txHold,
  input  logic                miso,
  output logic                mosi,
  output logic                lastBit,
  output logic                curEof,
  output logic                curHold,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxEof
);

  localparam logic [LEN_W-1:0] MIN_IDX = LEN_W'(MIN_BITS - 1);

  logic [MAX_BITS-1:0] dataReg;
  logic [MAX_BITS-1:0] rxShift;
  logic [LEN_W-1:0]    bitIdx;
  logic [LEN_W-1:0]    startIdx;

  // short length codes are clamped to the minimum word size
  assign startIdx = (txLen < MIN_IDX) ? MIN_IDX : txLen;
  assign lastBit  = (bitIdx == '0);
  assign mosi     = dataReg[bitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      rxShift <= '0;
      bitIdx  <= '0;
      curEof  <= 1'b0;
      curHold <= 1'b0;
      rxValid <= 1'b0;
      rxData  <= '0;
      rxEof   <= 1'b0;
    end else begin
      rxValid <= ctl.finish;
      if (ctl.finish) begin
        rxData <= rxShift;
        rxEof  <= curEof;
      end
      if (ctl.load) begin
        dataReg <= txData;
        bitIdx  <= startIdx;
        curEof  <= txEof;
        curHold <= txHold;
        rxShift <= '0;
      end else begin
        if (ctl.sample) rxShift <= {rxShift[MAX_BITS-2:0], miso};
        if (ctl.shift)  bitIdx  <= bitIdx - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_chain_ctrl.sv
module spi_chain_ctrl
  import spi_chain_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [DIV_W-1:0] frameDelay,
  input  logic             txValid,
  output logic             txReady,
  input  logic             lastBit,
  input  logic             curEof,
  input  logic             curHold,
  output dpCtrl_t          ctl,
  output logic             sck,
  output logic             csN
);

  ctrlState_t       state;
  logic             phase;     // 0: sck low half, 1: sck high half
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] gapCnt;
  logic             csActive;

  logic divDone, wordEnd, gapNeeded, chainNow, accept;

  assign divDone   = (divCnt == halfDiv);
  assign wordEnd   = (state == ST_SHIFT) && phase && divDone && lastBit;
  assign gapNeeded = curEof && (frameDelay != '0);
  assign chainNow  = wordEnd && curHold && !gapNeeded;
  assign txReady   = (state == ST_IDLE) || chainNow;
  assign accept    = txValid && txReady;

  always_comb begin
    ctl.load   = accept;
    ctl.sample = (state == ST_SHIFT) && !phase && divDone;
    ctl.shift  = (state == ST_SHIFT) && phase && divDone && !lastBit;
    ctl.finish = wordEnd;
  end

  assign sck = (state == ST_SHIFT) && phase;
  assign csN = !csActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      divCnt   <= '0;
      gapCnt   <= '0;
      csActive <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (txValid) begin
            state    <= ST_SHIFT;
            phase    <= 1'b0;
            divCnt   <= '0;
            csActive <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!divDone) begin
            divCnt <= divCnt + DIV_W'(1);
          end else begin
            divCnt <= '0;
            phase  <= !phase;
            if (phase && lastBit) begin
              if (gapNeeded) begin
                state    <= ST_GAP;
                gapCnt   <= '0;
                csActive <= curHold;
              end else if (chainNow && txValid) begin
                state <= ST_SHIFT;
              end else begin
                state    <= ST_IDLE;
                csActive <= curHold;
              end
            end
          end
        end
        ST_GAP: begin
          if (!divDone) begin
            divCnt <= divCnt + DIV_W'(1);
          end else begin
            divCnt <= '0;
            if (gapCnt == frameDelay - DIV_W'(1)) state <= ST_IDLE;
            else gapCnt <= gapCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_chain_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    halfDiv,
  input  logic [DIV_W-1:0]    frameDelay,
  input  logic                txValid,
  output logic                txReady,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [LEN_W-1:0]    txLen,
  input  logic                txEof,
  input  logic                txHold,
  output logic                sck,
  output logic                mosi,
  output logic                csN,
  input  logic                miso,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxEof
);

  dpCtrl_t ctl;
  logic    lastBit, curEof, curHold;

  spi_chain_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .halfDiv(halfDiv), .frameDelay(frameDelay),
    .txValid(txValid), .txReady(txReady), .lastBit(lastBit),
    .curEof(curEof), .curHold(curHold), .ctl(ctl), .sck(sck), .csN(csN)
  );

  spi_chain_dp #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .txLen(txLen),
    .txEof(txEof), .txHold(txHold), .miso(miso), .mosi(mosi),
    .lastBit(lastBit), .curEof(curEof), .curHold(curHold),
    .rxValid(rxValid), .rxData(rxData), .rxEof(rxEof)
  );

endmodule

// File: rtl/spi_chain_chk.sv
module spi_chain_chk (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic csN,
  input logic rxValid
);

  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_rx_sck_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !sck);

  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $rose(rxValid));

endmodule

bind spi_chain_master spi_chain_chk u_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .rxValid(rxValid)
);

// File: tb/spi_chain_master_tb.sv
module spi_chain_master_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  halfDiv, frameDelay;
  logic        txValid, txReady, txEof, txHold;
  logic [15:0] txData;
  logic [3:0]  txLen;
  logic        sck, mosi, csN, miso;
  logic        rxValid, rxEof;
  logic [15:0] rxData;

  always #5 clk = ~clk;

  spi_chain_master u_dut (
    .clk(clk), .rstN(rstN), .halfDiv(halfDiv), .frameDelay(frameDelay),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLen(txLen),
    .txEof(txEof), .txHold(txHold), .sck(sck), .mosi(mosi), .csN(csN),
    .miso(miso), .rxValid(rxValid), .rxData(rxData), .rxEof(rxEof)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model
  logic [63:0] slvPat;
  int          slvIdx;
  logic [63:0] capBits;
  int          capN;
  int          riseT [64];
  int          csRiseN;
  int          rxN;
  logic [15:0] rxLog [8];
  logic        rxEofLog [8];

  always @(negedge csN) begin
    slvIdx = 0;
    miso   = slvPat[63];
  end
  always @(negedge sck) if (!csN && slvIdx < 63) begin
    slvIdx++;
    miso = slvPat[63 - slvIdx];
  end
  always @(posedge sck) begin
    capBits = {capBits[62:0], mosi};
    if (capN < 64) riseT[capN] = cyc;
    capN++;
  end
  always @(posedge csN) csRiseN++;
  always @(negedge clk) if (rxValid && rxN < 8) begin
    rxLog[rxN]    = rxData;
    rxEofLog[rxN] = rxEof;
    rxN++;
  end

  // word queue for one chip-select session
  logic [15:0] qD [8];
  logic [3:0]  qL [8];
  logic        qE [8];
  logic        qH [8];
  int          qW [8];
  int          qN;

  function automatic int effLen(input logic [3:0] l);
    return (l < 4'd3) ? 4 : int'(l) + 1;
  endfunction

  task automatic addWord(input logic [15:0] d, input logic [3:0] l,
                         input logic e, input logic h, input int w);
    qD[qN] = d; qL[qN] = l; qE[qN] = e; qH[qN] = h; qW[qN] = w;
    qN++;
  endtask

  // runs queued words; expGap < 0 skips boundary timing checks
  task automatic runSession(input string req, input int h, input int d, input int expGap);
    logic [63:0] expBits;
    int          tot, off, wait_n;
    halfDiv = 8'(h); frameDelay = 8'(d);
    capN = 0; capBits = '0; csRiseN = 0; rxN = 0;
    @(negedge clk);
    for (int k = 0; k < qN; k++) begin
      if (qW[k] > 0) begin
        txValid = 1'b0;
        repeat (qW[k]) @(negedge clk);
        chk(csN == 1'b0, "R6", "csN held while waiting", csN, 0);
      end
      txData = qD[k]; txLen = qL[k]; txEof = qE[k]; txHold = qH[k];
      txValid = 1'b1;
      while (!txReady) @(negedge clk);
      @(negedge clk);
      chk(txReady == 1'b0, "R9", "txReady after accept", txReady, 0);
    end
    txValid = 1'b0;
    wait_n = 0;
    while (!(rxN == qN && csN) && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    // expected mosi stream
    expBits = '0; tot = 0;
    for (int k = 0; k < qN; k++)
      for (int b = effLen(qL[k]) - 1; b >= 0; b--) begin
        expBits = {expBits[62:0], qD[k][b]};
        tot++;
      end
    chk(capN == tot, req, "sck rising edge count", capN, tot);
    chk((capBits & ((64'd1 << tot) - 1)) == expBits, "R2", "mosi bits", capBits, expBits);
    chk(rxN == qN, "R5", "rxValid pulse count", rxN, qN);
    chk(csRiseN == 1, "R6", "csN rises once per session", csRiseN, 1);
    chk(riseT[1] - riseT[0] == 2 * (h + 1), "R4", "in-word rise interval",
        riseT[1] - riseT[0], 2 * (h + 1));
    off = 0;
    for (int k = 0; k < qN; k++) begin
      logic [15:0] e;
      e = '0;
      for (int b = 0; b < effLen(qL[k]); b++) e = {e[14:0], slvPat[63 - off - b]};
      if (k < rxN) begin
        chk(rxLog[k] == e, "R5", "rxData", rxLog[k], e);
        chk(rxEofLog[k] == qE[k], "R5", "rxEof", rxEofLog[k], qE[k]);
      end
      if (k > 0 && expGap >= 0 && off < capN)
        chk(riseT[off] - riseT[off - 1] == expGap, req, "boundary rise interval",
            riseT[off] - riseT[off - 1], expGap);
      off += effLen(qL[k]);
    end
    qN = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "csN after reset", csN, 1);
    chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
    chk(rxValid == 1'b0, "R1", "rxValid after reset", rxValid, 0);
    chk(txReady == 1'b1, "R1", "txReady after reset", txReady, 1);
  endtask

  task automatic testSingle();   // R2 R5
    slvPat = 64'hC3A5_5A3C_F00F_1234;
    addWord(16'h00A5, 4'd7, 1'b1, 1'b0, 0);
    runSession("R2", 1, 0, -1);
  endtask

  task automatic testChain16p8();  // R7
    slvPat = 64'h9B7E_2D41_0000_0000;
    addWord(16'hBEEF, 4'd15, 1'b0, 1'b1, 0);
    addWord(16'h00C4, 4'd7, 1'b1, 1'b0, 0);
    runSession("R7", 0, 0, 2);
  endtask

  task automatic testChain12p12();  // R7
    slvPat = 64'h5E3A_C1F7_0000_0000;
    addWord(16'h0ABC, 4'd11, 1'b0, 1'b1, 0);
    addWord(16'h0123, 4'd11, 1'b1, 1'b0, 0);
    runSession("R7", 2, 0, 6);
  endtask

  task automatic testChain3x8();  // R7
    slvPat = 64'hA17C_E933_0000_0000;
    addWord(16'h0081, 4'd7, 1'b0, 1'b1, 0);
    addWord(16'h007E, 4'd7, 1'b0, 1'b1, 0);
    addWord(16'h00D2, 4'd7, 1'b1, 1'b0, 0);
    runSession("R7", 1, 0, 4);
  endtask

  task automatic testShortLen();  // R3
    slvPat = 64'hB000_0000_0000_0000;
    addWord(16'hFFF9, 4'd1, 1'b1, 1'b0, 0);
    runSession("R3", 0, 0, -1);
    slvPat = 64'h6000_0000_0000_0000;
    addWord(16'h0006, 4'd0, 1'b1, 1'b0, 0);
    runSession("R3", 1, 0, -1);
  endtask

  task automatic testFrameDelay();  // R8
    slvPat = 64'h7F31_9C00_0000_0000;
    addWord(16'h00E7, 4'd7, 1'b1, 1'b1, 0);
    addWord(16'h0018, 4'd7, 1'b1, 1'b0, 0);
    runSession("R8", 1, 3, (2 + 3) * 2 + 1);
    slvPat = 64'h4D2B_0000_0000_0000;
    addWord(16'h0055, 4'd7, 1'b1, 1'b1, 0);
    addWord(16'h00AA, 4'd7, 1'b1, 1'b0, 0);
    runSession("R8", 1, 0, 4);
  endtask

  task automatic testHoldIdle();  // R6
    slvPat = 64'h8E6D_1000_0000_0000;
    addWord(16'h0033, 4'd5, 1'b0, 1'b1, 0);
    addWord(16'h0009, 4'd3, 1'b1, 1'b0, 20);
    runSession("R6", 0, 0, -1);
  endtask

  task automatic testSlowDiv();  // R4
    slvPat = 64'hD000_0000_0000_0000;
    addWord(16'h000B, 4'd3, 1'b1, 1'b0, 0);
    runSession("R4", 5, 0, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; txValid = 1'b0; txData = '0; txLen = '0; txEof = 1'b0;
    txHold = 1'b0; halfDiv = 8'd1; frameDelay = 8'd0; miso = 1'b0;
    slvPat = '0; slvIdx = 0; capN = 0; capBits = '0; csRiseN = 0; rxN = 0; qN = 0;
    testReset();
    testSingle();
    testChain16p8();
    testChain12p12();
    testChain3x8();
    testShortLen();
    testFrameDelay();
    testHoldIdle();
    testSlowDiv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule